// File: doc/BRIEF.md
# Channel Ready-Line Watchdog and Control/Status Register

This block is the per-channel control and status register of a disk-channel controller, with a hardware watchdog that supervises the device ready line during programmed-I/O transfers. Software reaches it through a simple synchronous register port with two registers, selected by one bit: a status/control register and a transfer-mode register.

The watchdog runs only while three conditions hold at once: its enable bit is set, the external ready-monitoring input is high and a programmed-I/O transfer is in progress. Each low period of the ready line is timed afresh. If the line stays low for the full limit (256 clock cycles by default), a sticky timeout flag is latched. The channel keeps running; only the watchdog stops supervising until software clears the flag by writing one to it. The flag, gated by an interrupt-enable bit and ORed with an external channel interrupt source, drives a registered interrupt request.

The block also holds the channel reset bit, which drives the reset output, and a DMA-completion flag that the bus-master enable input clears. The transfer-mode register holds a 2-bit code for each of two devices, and the block decodes each code to a DMA/PIO select.

Top module: `chan_rdy_guard`

## Requirements
- R1: After reset the status register reads 0x0001, the mode register reads 0x0022, and `irq`, `chan_rst` are 0.
- R2: In the status register (`reg_sel`=0), bit 14 is interrupt enable, bit 13 is watchdog enable and bit 2 is channel reset, all read/write. Bit 0 always reads 1, and bits 15, 9..3 and 1 always read 0.
- R3: `chan_rst` equals status bit 2 from the cycle after the write that sets or clears it.
- R4: In the mode register (`reg_sel`=1), bits 1:0 hold device 0's code and bits 5:4 hold device 1's code. All other bits read 0. `dev_dma[i]` is 1 for codes 10 and 11 and 0 for codes 00 and 01.
- R5: With the watchdog armed, status bit 12 (timeout) becomes 1 after exactly 256 consecutive rising edges at which `dev_ready` is sampled low. It stays 0 after 255.
- R6: A return of `dev_ready` high before expiry resets the count, and separate low pulses do not accumulate.
- R7: The watchdog is armed only when the watchdog enable bit, `mon_enable` and `pio_active` are all 1 and the timeout flag is 0. Otherwise it never expires.
- R8: The timeout flag is sticky. Writing 0 to bit 12 has no effect, and writing 1 clears it. While the flag is set the line is not supervised, and after a clear a fresh full 256-cycle low period is needed.
- R9: A write of 1 to bit 12 in the same cycle as an expiry leaves the flag set.
- R10: `irq` is a register loaded with (timeout AND interrupt enable) OR `ext_irq`, so it changes one cycle after its inputs. Status bit 11 shows the same expression without the register.
- R11: Status bit 10 is set by `dma_done` while `bm_enable` is 1. It is 0 whenever `bm_enable` was 0 at the previous edge.
- R12: Clearing the watchdog enable bit resets the count, so a later low period must last the full 256 cycles. It leaves an already latched timeout flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 status, 1 mode |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register |
| dev_ready | input | 1 | Device ready line, low means the device is stalling |
| pio_active | input | 1 | Programmed-I/O transfer in progress |
| mon_enable | input | 1 | Ready-line monitoring enable |
| ext_irq | input | 1 | External channel interrupt source |
| dma_done | input | 1 | DMA completion event |
| bm_enable | input | 1 | Bus-master enable, low clears the completion flag |
| irq | output | 1 | Registered interrupt request |
| chan_rst | output | 1 | Channel reset output |
| dev_dma | output | 2 | Per-device DMA select decoded from the mode codes |

## Verification
The bench sweeps low-pulse lengths from 250 to 257 cycles. A counter off by one in either direction shows up as a flag at 255 or a missing flag at 256. Chains of short pulses followed by a 255-cycle pulse catch a counter that accumulates instead of restarting. A clear issued on the exact expiry edge catches a design that lets the clear win. Pulses held low while the flag is set, and while the enable is toggled, catch a watchdog that keeps counting when it should be parked, since it would then expire early after re-arming. All seven non-armed combinations of the three gating conditions are held low for 300 cycles, and every mode code pair is written and decoded.

// File: rtl/chan_guard_pkg.sv
package chan_guard_pkg;

    localparam int REG_W       = 16;
    localparam int NUM_DEV     = 2;
    localparam int MODE_W      = 2;
    localparam int MODE_STRIDE = 4;

    localparam logic SEL_STATUS = 1'b0;
    localparam logic SEL_MODE   = 1'b1;

    // status register bit positions
    localparam int B_IRQ_EN   = 14;
    localparam int B_WD_EN    = 13;
    localparam int B_TIMEOUT  = 12;
    localparam int B_PEND     = 11;
    localparam int B_DMA_DONE = 10;
    localparam int B_CHAN_RST = 2;
    localparam int B_ONE      = 0;

    localparam logic [MODE_W-1:0] MODE_RESET = 2'b10;

    typedef struct packed {
        logic irq_en;
        logic wd_en;
        logic timeout;
        logic dma_flag;
        logic chan_rst;
        logic irq;
    } status_t;

endpackage

// File: rtl/rdy_watchdog.sv
module rdy_watchdog #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic ready,
    output logic expire
);
    localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = '0;
        expire = 1'b0;
        if (arm && !ready) begin
            if (cnt_q == LAST) begin
                expire = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/xfer_mode_reg.sv
module xfer_mode_reg
    import chan_guard_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic [REG_W-1:0]                wdata,
    output logic [NUM_DEV-1:0][MODE_W-1:0]  mode,
    output logic [NUM_DEV-1:0]              is_dma
);
    logic [NUM_DEV-1:0][MODE_W-1:0] mode_d, mode_q;
    logic unused_wdata;

    assign unused_wdata = ^wdata;

    always_comb begin
        mode_d = mode_q;
        if (we) begin
            for (int i = 0; i < NUM_DEV; i++) begin
                mode_d[i] = wdata[i*MODE_STRIDE +: MODE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= {NUM_DEV{MODE_RESET}};
        else        mode_q <= mode_d;
    end

    assign mode = mode_q;

    generate
        for (genvar g = 0; g < NUM_DEV; g++) begin : g_dec
            assign is_dma[g] = mode_q[g][MODE_W-1];
        end
    endgenerate
endmodule

// File: rtl/chan_rdy_guard.sv
module chan_rdy_guard
    import chan_guard_pkg::*;
#(
    parameter int WD_LIMIT = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic               reg_sel,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic               dev_ready,
    input  logic               pio_active,
    input  logic               mon_enable,
    input  logic               ext_irq,
    input  logic               dma_done,
    input  logic               bm_enable,
    output logic               irq,
    output logic               chan_rst,
    output logic [NUM_DEV-1:0] dev_dma
);
    status_t st_d, st_q;
    logic wr_status, wr_mode, wd_arm, wd_expire, pend_now;
    logic timeout_flag, irq_en_flag, dma_flag;
    logic [NUM_DEV-1:0][MODE_W-1:0] mode;

    assign wr_status = reg_we && (reg_sel == SEL_STATUS);
    assign wr_mode   = reg_we && (reg_sel == SEL_MODE);
    assign wd_arm    = st_q.wd_en && mon_enable && pio_active && !st_q.timeout;
    assign pend_now  = (st_q.timeout && st_q.irq_en) || ext_irq;

    rdy_watchdog #(.LIMIT(WD_LIMIT)) u_wd (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (wd_arm),
        .ready  (dev_ready),
        .expire (wd_expire)
    );

    xfer_mode_reg u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wr_mode),
        .wdata  (reg_wdata),
        .mode   (mode),
        .is_dma (dev_dma)
    );

    always_comb begin
        st_d = st_q;
        if (wr_status) begin
            st_d.irq_en   = reg_wdata[B_IRQ_EN];
            st_d.wd_en    = reg_wdata[B_WD_EN];
            st_d.chan_rst = reg_wdata[B_CHAN_RST];
            if (reg_wdata[B_TIMEOUT]) st_d.timeout = 1'b0;
        end
        // expiry wins over a simultaneous clear
        if (wd_expire) st_d.timeout = 1'b1;
        if (!bm_enable)    st_d.dma_flag = 1'b0;
        else if (dma_done) st_d.dma_flag = 1'b1;
        st_d.irq = pend_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_sel == SEL_STATUS) begin
            reg_rdata[B_IRQ_EN]   = st_q.irq_en;
            reg_rdata[B_WD_EN]    = st_q.wd_en;
            reg_rdata[B_TIMEOUT]  = st_q.timeout;
            reg_rdata[B_PEND]     = pend_now;
            reg_rdata[B_DMA_DONE] = st_q.dma_flag;
            reg_rdata[B_CHAN_RST] = st_q.chan_rst;
            reg_rdata[B_ONE]      = 1'b1;
        end else begin
            for (int i = 0; i < NUM_DEV; i++) begin
                reg_rdata[i*MODE_STRIDE +: MODE_W] = mode[i];
            end
        end
    end

    assign irq          = st_q.irq;
    assign chan_rst     = st_q.chan_rst;
    assign timeout_flag = st_q.timeout;
    assign irq_en_flag  = st_q.irq_en;
    assign dma_flag     = st_q.dma_flag;
endmodule

// File: rtl/chan_rdy_guard_chk.sv
module chan_rdy_guard_chk
    import chan_guard_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic             reg_sel,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic             mon_enable,
    input logic             ext_irq,
    input logic             bm_enable,
    input logic             irq,
    input logic             chan_rst,
    input logic             timeout_flag,
    input logic             irq_en_flag,
    input logic             dma_flag,
    input logic             wd_expire
);
    logic w1c;
    assign w1c = reg_we && (reg_sel == SEL_STATUS) && reg_wdata[B_TIMEOUT];

    p_status_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == SEL_STATUS) |-> (reg_rdata[B_ONE] && !reg_rdata[15]
                                     && reg_rdata[9:3] == '0 && !reg_rdata[1]));

    p_rst_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == SEL_STATUS) |=> (chan_rst == $past(reg_wdata[B_CHAN_RST])));

    p_mode_reserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == SEL_MODE) |-> (reg_rdata[15:6] == '0 && reg_rdata[3:2] == '0));

    p_idle_no_expire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_enable |-> !wd_expire);

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_flag && !w1c) |=> timeout_flag);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_flag && w1c && !wd_expire) |=> !timeout_flag);

    p_expire_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wd_expire |=> timeout_flag);

    p_irq_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq == $past((timeout_flag && irq_en_flag) || ext_irq)));

    p_dma_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bm_enable |=> !dma_flag);
endmodule

bind chan_rdy_guard chan_rdy_guard_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_we       (reg_we),
    .reg_sel      (reg_sel),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .mon_enable   (mon_enable),
    .ext_irq      (ext_irq),
    .bm_enable    (bm_enable),
    .irq          (irq),
    .chan_rst     (chan_rst),
    .timeout_flag (timeout_flag),
    .irq_en_flag  (irq_en_flag),
    .dma_flag     (dma_flag),
    .wd_expire    (wd_expire)
);

// File: tb/tb_chan_rdy_guard.sv
module tb_chan_rdy_guard;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 256;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        dev_ready = 1'b1;
    logic        pio_active = 1'b0;
    logic        mon_enable = 1'b0;
    logic        ext_irq = 1'b0;
    logic        dma_done = 1'b0;
    logic        bm_enable = 1'b0;
    logic        irq, chan_rst;
    logic [1:0]  dev_dma;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_rdy_guard #(.WD_LIMIT(LIMIT)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_ready(dev_ready),
        .pio_active(pio_active), .mon_enable(mon_enable), .ext_irq(ext_irq),
        .dma_done(dma_done), .bm_enable(bm_enable), .irq(irq),
        .chan_rst(chan_rst), .dev_dma(dev_dma)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WATCHDOG) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<%0d cycles", cyc, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        tick();
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic sel, output logic [15:0] v);
        reg_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    task automatic flag(output logic f);
        logic [15:0] v;
        rd(1'b0, v);
        f = v[12];
    endtask

    initial begin
        logic [15:0] v;
        logic f;

        ticks(3);
        rst_n = 1'b1;
        tick();

        // R1 reset state
        rd(1'b0, v); chk("R1 status", v, 16'h0001);
        rd(1'b1, v); chk("R1 mode", v, 16'h0022);
        chk("R1 irq", irq, 0);
        chk("R1 chan_rst", chan_rst, 0);

        // R2 / R3 status read-write
        wr(1'b0, 16'hFFFF);
        rd(1'b0, v); chk("R2 all ones", v, 16'h6005);
        chk("R3 rst set", chan_rst, 1);
        wr(1'b0, 16'h0000);
        rd(1'b0, v); chk("R2 all zero", v, 16'h0001);
        chk("R3 rst clear", chan_rst, 0);
        wr(1'b0, 16'h0004);
        chk("R3 rst only", chan_rst, 1);
        wr(1'b0, 16'h0000);

        // R4 mode sweep
        for (int c0 = 0; c0 < 4; c0++) begin
            for (int c1 = 0; c1 < 4; c1++) begin
                logic [15:0] d;
                d = 16'hFFCC | 16'(c0) | (16'(c1) << 4);
                wr(1'b1, d);
                rd(1'b1, v);
                chk("R4 mode read", v, 16'(c0) | (16'(c1) << 4));
                chk("R4 decode", dev_dma, {c1[1], c0[1]});
            end
        end

        // arm watchdog
        mon_enable = 1'b1; pio_active = 1'b1; dev_ready = 1'b1;
        wr(1'b0, 16'h6000);

        // R5 exact expiry, R10 latency
        dev_ready = 1'b0;
        ticks(LIMIT - 1);
        flag(f); chk("R5 255 low", f, 0);
        chk("R10 irq before", irq, 0);
        tick();
        flag(f); chk("R5 256 low", f, 1);
        chk("R10 irq one cycle late", irq, 0);
        rd(1'b0, v); chk("R10 live pending bit", v[11], 1);
        tick();
        chk("R10 irq raised", irq, 1);
        dev_ready = 1'b1;

        // R8 sticky, parked, resume
        wr(1'b0, 16'h6000);
        flag(f); chk("R8 write zero no effect", f, 1);
        dev_ready = 1'b0;
        ticks(300);
        wr(1'b0, 16'h7000);
        flag(f); chk("R8 cleared", f, 0);
        chk("R10 irq still registered", irq, 1);
        tick();
        chk("R10 irq dropped", irq, 0);
        ticks(LIMIT - 2);
        flag(f); chk("R8 resume needs full period", f, 0);
        tick();
        flag(f); chk("R8 resume expiry", f, 1);
        dev_ready = 1'b1;

        // R9 expiry beats clear
        wr(1'b0, 16'h7000);
        dev_ready = 1'b0;
        ticks(LIMIT - 1);
        wr(1'b0, 16'h7000);
        flag(f); chk("R9 expiry wins", f, 1);
        dev_ready = 1'b1;
        wr(1'b0, 16'h7000);

        // R6 no accumulation
        begin
            int lens[5] = '{1, 2, 100, 254, 255};
            foreach (lens[k]) begin
                dev_ready = 1'b0;
                ticks(lens[k]);
                dev_ready = 1'b1;
                tick();
                flag(f); chk("R6 short pulse", f, 0);
            end
            dev_ready = 1'b0;
            ticks(LIMIT - 1);
            dev_ready = 1'b1;
            tick();
            flag(f); chk("R6 no accumulation", f, 0);
        end

        // R5 boundary sweep
        for (int len = LIMIT - 6; len <= LIMIT + 1; len++) begin
            wr(1'b0, 16'h7000);
            dev_ready = 1'b0;
            ticks(len);
            flag(f); chk("R5 sweep", f, (len >= LIMIT) ? 1 : 0);
            dev_ready = 1'b1;
            tick();
        end

        // R12 disable resets count, keeps flag
        wr(1'b0, 16'h7000);
        dev_ready = 1'b0;
        ticks(200);
        wr(1'b0, 16'h4000);
        wr(1'b0, 16'h6000);
        ticks(LIMIT - 1);
        flag(f); chk("R12 count restarted", f, 0);
        tick();
        flag(f); chk("R12 full period expiry", f, 1);
        wr(1'b0, 16'h4000);
        flag(f); chk("R12 disable keeps flag", f, 1);
        dev_ready = 1'b1;

        // R10 gating and external source
        wr(1'b0, 16'h0000);
        tick();
        chk("R10 gated off", irq, 0);
        ext_irq = 1'b1;
        rd(1'b0, v); chk("R10 live ext", v[11], 1);
        chk("R10 ext not yet", irq, 0);
        tick();
        chk("R10 ext irq", irq, 1);
        ext_irq = 1'b0;
        tick();
        chk("R10 ext irq gone", irq, 0);

        // R7 gating combinations
        wr(1'b0, 16'h1000);
        for (int g = 0; g < 7; g++) begin
            logic [2:0] gb;
            gb = 3'(g);
            wr(1'b0, gb[0] ? 16'h2000 : 16'h0000);
            mon_enable = gb[1];
            pio_active = gb[2];
            dev_ready = 1'b0;
            ticks(300);
            flag(f); chk("R7 not armed", f, 0);
            dev_ready = 1'b1;
            tick();
        end

        // R11 dma completion flag
        bm_enable = 1'b1; dma_done = 1'b1;
        tick();
        dma_done = 1'b0;
        rd(1'b0, v); chk("R11 set", v[10], 1);
        tick();
        rd(1'b0, v); chk("R11 held", v[10], 1);
        bm_enable = 1'b0;
        tick();
        rd(1'b0, v); chk("R11 cleared", v[10], 0);
        dma_done = 1'b1;
        tick();
        dma_done = 1'b0;
        rd(1'b0, v); chk("R11 ignored without enable", v[10], 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule